// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Access Controller

This block gives software access to a fuse array of 768 words of 32 bits, over a small register bus. Software writes a command word that holds a start word index, a burst length and an operation code. It then writes a one to a start register. A read copies between one and eight consecutive words into a bank of result registers. A program operation ORs a 32-bit pattern into one word. The array model can only set bits, never clear them. A configurable defect mask marks bits that never blow, so that a failed program can be shown.

Each operation ends by raising one outcome flag in a status register: read done, program done, verify failure or error. Software clears these flags by writing ones to them. A busy flag in the same register shows an operation in progress. Every operation finishes within a few cycles, so a software poll loop always sees it end.

Top module: `fuse_access_ctrl`

## Requirements
- R1: After reset, every status bit reads 0 and every result register reads 0.
- R2: The command register sits at offset 0x04, program data at 0x10 and the start register at 0x08, and the first two read back what was written. Command word fields: bits 31:16 are the start index, bits 15:8 are the burst length, and bits 7:0 are the operation code (0 = read, 2 = program).
- R3: A read of length N (1..8) from index I places word I+k in the result register at offset 0x20+4k, and sets status bit 1. Result registers at or beyond N keep their previous values.
- R4: A program operation stores the old word ORed with the program data, sets status bit 3, and never clears a bit that is already 1.
- R5: After burning, the controller reads the word back. If any requested bit is still 0, it sets status bit 2 instead of bit 3.
- R6: An operation whose index plus length exceeds 768 sets status bit 4. It does not touch the array or the result registers.
- R7: A read with a burst length of 0 or more than 8 sets status bit 4 and changes no result register.
- R8: A program operation touches exactly one word, whatever the burst length field holds.
- R9: A start write while busy (status bit 0 = 1) is ignored and sets status bit 4. The running operation completes unchanged.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it. Writing back a value just read clears every pending outcome bit.
- R11: Outcome flags are mutually exclusive per operation. A read of length N stays busy for N+1 cycles and a program stays busy for 4 cycles.
- R12: An unknown operation code sets status bit 4 and leaves the array unchanged. A write of 0 to the start register does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is 1 |
| bus_rvalid | output | 1 | High for one cycle, the cycle after a read strobe |

## Verification
Programs are tried with fresh bits, with bits already set, and with a bit inside the defect mask. This separates a true OR from an overwrite, and a verify failure from a plain done. Reads of length 1, 2, 3 and 8 tell a correct slot mapping apart from stale or shifted result registers. Reads that end exactly at the last word are set against reads one word past it, which exposes an off-by-one in the range check. Back-to-back start writes, unknown codes and zero-length bursts show that rejected requests leave the array and the result registers untouched.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned BUS_AW = 8;

  localparam logic [BUS_AW-1:0] OFF_CTRL  = 8'h04;
  localparam logic [BUS_AW-1:0] OFF_GO    = 8'h08;
  localparam logic [BUS_AW-1:0] OFF_PDATA = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_DOUT  = 8'h20;
  localparam logic [BUS_AW-1:0] OFF_STAT  = 8'h84;

  localparam logic [7:0] OP_READ = 8'd0;
  localparam logic [7:0] OP_BURN = 8'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ISSUE, S_RD_DRAIN, S_PG_FETCH, S_PG_BURN, S_PG_RECHK, S_PG_JUDGE
  } seq_state_e;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int unsigned WORDS       = 768,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 10,
  parameter logic [DW-1:0] INIT_WORD   = '0,
  parameter logic [DW-1:0] DEFECT_MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rdata_q;

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = INIT_WORD & ~DEFECT_MASK;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i & ~DEFECT_MASK;
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

  // R4
  burn_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |-> ((mem[waddr_i] & ~wdata_i) == '0));
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int unsigned WORDS     = 768,
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 10,
  parameter int unsigned MAX_BURST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [31:0]   ctrl_i,
  input  logic [DW-1:0] pdata_i,
  input  logic [DW-1:0] fa_rdata_i,
  output logic          busy_o,
  output logic          fa_re_o,
  output logic [AW-1:0] fa_raddr_o,
  output logic          fa_we_o,
  output logic [AW-1:0] fa_waddr_o,
  output logic [DW-1:0] fa_wdata_o,
  output logic          dout_we_o,
  output logic [$clog2(MAX_BURST)-1:0] dout_slot_o,
  output logic          rd_done_o,
  output logic          pg_done_o,
  output logic          vfail_o,
  output logic          err_o
);
  localparam int unsigned SW = $clog2(MAX_BURST);
  localparam int unsigned CW = $clog2(MAX_BURST + 1);

  seq_state_e    st;
  logic [AW-1:0] base_q;
  logic [SW-1:0] n_q, cap_slot;
  logic [CW-1:0] num_q;
  logic [DW-1:0] pd_q;
  logic          cap_vld;

  logic [7:0]  op, len;
  logic [15:0] idx;
  logic        is_rd, is_pg, bad;
  logic [8:0]  span;
  logic [16:0] last_word;

  always_comb begin
    op        = ctrl_i[7:0];
    len       = ctrl_i[15:8];
    idx       = ctrl_i[31:16];
    is_rd     = (op == OP_READ);
    is_pg     = (op == OP_BURN);
    span      = is_pg ? 9'd1 : {1'b0, len};
    last_word = {1'b0, idx} + {8'b0, span};
    bad       = !(is_rd || is_pg)
              || (is_rd && (len == 8'd0 || len > 8'(MAX_BURST)))
              || (last_word > 17'(WORDS));
  end

  assign busy_o      = (st != S_IDLE);
  assign fa_re_o     = (st == S_RD_ISSUE) || (st == S_PG_FETCH) || (st == S_PG_RECHK);
  assign fa_raddr_o  = (st == S_RD_ISSUE) ? base_q + AW'(n_q) : base_q;
  assign fa_we_o     = (st == S_PG_BURN);
  assign fa_waddr_o  = base_q;
  assign fa_wdata_o  = fa_rdata_i | pd_q;
  assign dout_we_o   = cap_vld;
  assign dout_slot_o = cap_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; base_q <= '0; n_q <= '0; num_q <= '0; pd_q <= '0;
      cap_vld <= 1'b0; cap_slot <= '0;
      rd_done_o <= 1'b0; pg_done_o <= 1'b0; vfail_o <= 1'b0; err_o <= 1'b0;
    end else begin
      cap_vld <= 1'b0;
      rd_done_o <= 1'b0; pg_done_o <= 1'b0; vfail_o <= 1'b0; err_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          if (bad) err_o <= 1'b1;
          else begin
            base_q <= idx[AW-1:0];
            pd_q   <= pdata_i;
            n_q    <= '0;
            num_q  <= len[CW-1:0];
            st     <= is_rd ? S_RD_ISSUE : S_PG_FETCH;
          end
        end
        S_RD_ISSUE: begin
          cap_vld  <= 1'b1;
          cap_slot <= n_q;
          if (CW'(n_q) + CW'(1) == num_q) st <= S_RD_DRAIN;
          else n_q <= n_q + SW'(1);
        end
        S_RD_DRAIN: begin rd_done_o <= 1'b1; st <= S_IDLE; end
        S_PG_FETCH: st <= S_PG_BURN;
        S_PG_BURN:  st <= S_PG_RECHK;
        S_PG_RECHK: st <= S_PG_JUDGE;
        S_PG_JUDGE: begin
          if ((fa_rdata_i & pd_q) == pd_q) pg_done_o <= 1'b1;
          else vfail_o <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_run <= '0;
    else if (busy_run != 8'hFF) busy_run <= busy_run + 8'd1;
  end

  // R11
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_done_o, pg_done_o, vfail_o, err_o}));
  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy_run <= 8'(MAX_BURST + 1));
  // R6
  bad_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start_i && bad) |=> (!busy_o && !fa_we_o && err_o));
  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    fa_re_o |-> (32'(fa_raddr_o) < WORDS));
endmodule

// File: rtl/fuse_access_ctrl.sv
module fuse_access_ctrl
  import fuse_pkg::*;
#(
  parameter int unsigned WORDS       = 768,
  parameter int unsigned DW          = 32,
  parameter int unsigned MAX_BURST   = 8,
  parameter logic [DW-1:0] INIT_WORD   = '0,
  parameter logic [DW-1:0] DEFECT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid
);
  localparam int unsigned AW = $clog2(WORDS);
  localparam int unsigned SW = $clog2(MAX_BURST);

  logic [31:0]   ctrl_q;
  logic [DW-1:0] pdata_q, rdata_q, rd_mux;
  logic [DW-1:0] dout_q [MAX_BURST];
  logic [4:1]    stat_q, stat_set, stat_clr;
  logic          rvalid_q;

  logic          seq_busy, fa_re, fa_we, dout_we;
  logic [AW-1:0] fa_raddr, fa_waddr;
  logic [DW-1:0] fa_wdata, fa_rdata;
  logic [SW-1:0] dout_slot;
  logic          rd_done, pg_done, vfail, seq_err;

  logic              wr, go_hit, start, busy_err, in_dout;
  logic [BUS_AW-1:0] dout_off;

  assign wr       = bus_req && bus_we;
  assign go_hit   = wr && (bus_addr == OFF_GO) && bus_wdata[0];
  assign start    = go_hit && !seq_busy;
  assign busy_err = go_hit && seq_busy;
  assign dout_off = bus_addr - OFF_DOUT;
  assign in_dout  = (bus_addr >= OFF_DOUT) && (32'(dout_off) < 4 * MAX_BURST);
  assign stat_set = {seq_err | busy_err, pg_done, vfail, rd_done};
  assign stat_clr = (wr && bus_addr == OFF_STAT) ? bus_wdata[4:1] : 4'b0;

  fuse_seq #(.WORDS(WORDS), .DW(DW), .AW(AW), .MAX_BURST(MAX_BURST)) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .ctrl_i(ctrl_q), .pdata_i(pdata_q),
    .fa_rdata_i(fa_rdata), .busy_o(seq_busy), .fa_re_o(fa_re), .fa_raddr_o(fa_raddr),
    .fa_we_o(fa_we), .fa_waddr_o(fa_waddr), .fa_wdata_o(fa_wdata),
    .dout_we_o(dout_we), .dout_slot_o(dout_slot), .rd_done_o(rd_done),
    .pg_done_o(pg_done), .vfail_o(vfail), .err_o(seq_err)
  );

  fuse_array #(.WORDS(WORDS), .DW(DW), .AW(AW), .INIT_WORD(INIT_WORD),
               .DEFECT_MASK(DEFECT_MASK)) u_array (
    .clk(clk), .rst(rst), .re_i(fa_re), .raddr_i(fa_raddr), .rdata_o(fa_rdata),
    .we_i(fa_we), .waddr_i(fa_waddr), .wdata_i(fa_wdata)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_CTRL)       rd_mux = DW'(ctrl_q);
    else if (bus_addr == OFF_PDATA) rd_mux = pdata_q;
    else if (bus_addr == OFF_STAT)  rd_mux = DW'({stat_q, seq_busy});
    else if (in_dout)               rd_mux = dout_q[dout_off[SW+1:2]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; pdata_q <= '0; stat_q <= '0; rdata_q <= '0; rvalid_q <= 1'b0;
      for (int k = 0; k < MAX_BURST; k++) dout_q[k] <= '0;
    end else begin
      if (wr && bus_addr == OFF_CTRL)  ctrl_q  <= bus_wdata[31:0];
      if (wr && bus_addr == OFF_PDATA) pdata_q <= bus_wdata;
      stat_q   <= (stat_q & ~stat_clr) | stat_set;
      rvalid_q <= bus_req && !bus_we;
      if (bus_req && !bus_we) rdata_q <= rd_mux;
      for (int k = 0; k < MAX_BURST; k++)
        if (dout_we && dout_slot == SW'(k)) dout_q[k] <= fa_rdata;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R9
  busy_start_err_chk: assert property (@(posedge clk) disable iff (rst)
    (go_hit && seq_busy) |=> stat_q[4]);
  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == OFF_STAT && bus_wdata[1] && !rd_done) |=> !stat_q[1]);
  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_we |=> $stable(dout_q[0]));
endmodule

// File: tb/sim_fuse_access_ctrl.sv
module sim_fuse_access_ctrl;
  localparam logic [7:0] A_CTRL = 8'h04, A_GO = 8'h08, A_PD = 8'h10,
                         A_DOUT = 8'h20, A_STAT = 8'h84;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  fuse_access_ctrl #(.DEFECT_MASK(32'h8000_0000)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  typedef struct { bit chk; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      item_t it;
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 unexpected read data actual %h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (it.chk) begin
          n_cmp++;
          if (bus_rdata !== it.exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", it.tag, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input bit chk, input logic [31:0] e,
                          input string tag, output logic [31:0] d);
    item_t it;
    it.chk = chk; it.exp = e; it.tag = tag;
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a; sb_q.push_back(it);
    @(negedge clk); bus_req = 0; d = bus_rdata;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    bus_read(a, 1, e, tag, d);
  endtask

  task automatic wait_idle(input int limit);
    logic [31:0] d;
    int polls = 0;
    do begin bus_read(A_STAT, 0, '0, "", d); polls++; end while (d[0] && polls < 50);
    n_cmp++;
    if (polls > limit) begin
      n_bad++;
      $display("FAIL R11 busy polls actual %0d expected <= %0d", polls, limit);
    end
  endtask

  task automatic run(input logic [31:0] c, input logic [31:0] p, input int limit);
    bus_write(A_CTRL, c); bus_write(A_PD, p); bus_write(A_GO, 32'd1); wait_idle(limit);
  endtask

  task automatic prog(input logic [15:0] i, input logic [31:0] v, input logic [7:0] b);
    run({i, b, 8'd2}, v, 3);
  endtask

  task automatic rd(input logic [15:0] i, input logic [7:0] n);
    run({i, n, 8'd0}, 32'h0, 6);
  endtask

  task automatic clr(); bus_write(A_STAT, 32'h1E); endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    expect_rd(A_STAT, 32'h0, "R1 status after reset");
    expect_rd(A_DOUT, 32'h0, "R1 result slot0 after reset");
    expect_rd(A_DOUT + 8'd28, 32'h0, "R1 result slot7 after reset");
    // R2 register map and readback
    bus_write(A_CTRL, 32'h0005_0302);
    expect_rd(A_CTRL, 32'h0005_0302, "R2 command readback");
    bus_write(A_PD, 32'hA5A5_0000);
    expect_rd(A_PD, 32'hA5A5_0000, "R2 program data readback");
    // R4 program fresh bits
    prog(16'd5, 32'h0000_00F0, 8'd0);
    expect_rd(A_STAT, 32'h08, "R4 program done");
    bus_write(A_STAT, 32'h08);
    expect_rd(A_STAT, 32'h0, "R10 write one clears");
    prog(16'd5, 32'h0F00_0000, 8'd0);
    expect_rd(A_STAT, 32'h08, "R4 second program done");
    bus_read(A_STAT, 0, '0, "", d);
    bus_write(A_STAT, d);
    expect_rd(A_STAT, 32'h0, "R10 write back clears all");
    // R8 burst field ignored on program
    prog(16'd6, 32'h0000_0001, 8'd7);
    expect_rd(A_STAT, 32'h08, "R8 program with burst field");
    clr();
    // R3 read burst
    rd(16'd5, 8'd3);
    expect_rd(A_STAT, 32'h02, "R3 read done");
    expect_rd(A_DOUT, 32'h0F00_00F0, "R4 OR result slot0");
    expect_rd(A_DOUT + 8'd4, 32'h1, "R3 slot1 word6");
    expect_rd(A_DOUT + 8'd8, 32'h0, "R8 word7 untouched");
    clr();
    // R4 monotonic: set bits stay, new bit joins
    prog(16'd5, 32'h0000_0001, 8'd0);
    clr();
    rd(16'd5, 8'd1);
    expect_rd(A_DOUT, 32'h0F00_00F1, "R4 monotonic OR");
    expect_rd(A_DOUT + 8'd4, 32'h1, "R3 slot beyond length kept");
    clr();
    // R5 verify failure on defect bit
    prog(16'd7, 32'h8000_0001, 8'd0);
    expect_rd(A_STAT, 32'h04, "R5 verify fail");
    clr();
    rd(16'd7, 8'd1);
    expect_rd(A_DOUT, 32'h1, "R5 partial burn");
    clr();
    // R6 range limits
    prog(16'h2FF, 32'h55, 8'd0);
    expect_rd(A_STAT, 32'h08, "R6 last word program");
    clr();
    rd(16'h2FE, 8'd2);
    expect_rd(A_STAT, 32'h02, "R6 read ends at last word");
    expect_rd(A_DOUT + 8'd4, 32'h55, "R6 last word data");
    clr();
    rd(16'h2FE, 8'd3);
    expect_rd(A_STAT, 32'h10, "R6 read past end error");
    expect_rd(A_DOUT + 8'd4, 32'h55, "R6 result untouched");
    clr();
    prog(16'h300, 32'h1, 8'd0);
    expect_rd(A_STAT, 32'h10, "R6 program past end error");
    clr();
    // R7 bad burst lengths
    rd(16'd5, 8'd0);
    expect_rd(A_STAT, 32'h10, "R7 zero length");
    clr();
    rd(16'd5, 8'd9);
    expect_rd(A_STAT, 32'h10, "R7 length nine");
    expect_rd(A_DOUT, 32'h0, "R7 result untouched");
    clr();
    // R12 unknown code, zero start write
    run({16'd6, 8'd1, 8'd1}, 32'hFFFF_FFFF, 3);
    expect_rd(A_STAT, 32'h10, "R12 unknown code error");
    clr();
    bus_write(A_CTRL, {16'd5, 8'd1, 8'd0});
    bus_write(A_GO, 32'd0);
    repeat (4) @(negedge clk);
    expect_rd(A_STAT, 32'h0, "R12 zero start ignored");
    rd(16'd6, 8'd1);
    expect_rd(A_DOUT, 32'h1, "R12 array unchanged");
    clr();
    // R9 start while busy
    bus_write(A_CTRL, {16'd0, 8'd8, 8'd0});
    bus_write(A_GO, 32'd1);
    bus_write(A_GO, 32'd1);
    wait_idle(6);
    expect_rd(A_STAT, 32'h12, "R9 busy start error plus done");
    expect_rd(A_DOUT, 32'h0, "R9 burst slot0");
    expect_rd(A_DOUT + 8'd20, 32'h0F00_00F1, "R9 burst slot5");
    expect_rd(A_DOUT + 8'd24, 32'h1, "R9 burst slot6");
    expect_rd(A_DOUT + 8'd28, 32'h1, "R9 burst slot7");
    // R10 partial clears
    bus_write(A_STAT, 32'h02);
    expect_rd(A_STAT, 32'h10, "R10 partial clear");
    bus_write(A_STAT, 32'h0);
    expect_rd(A_STAT, 32'h10, "R10 zero write keeps");
    bus_write(A_STAT, 32'h10);
    expect_rd(A_STAT, 32'h0, "R10 error cleared");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule